// File: doc/BRIEF.md
# Sum-Addressed Dual-Bank Wordline Decoder

This block drives the wordlines of a direct-mapped cache array straight from the two operands of a load address: a base register value and an offset. It does not first add them with a carry-propagating adder and then decode the sum. Each row instead reduces base, offset and its own inverted line number into carry-save form and checks that the result is all ones. The row reads that check from four shared per-bit signals, each built from a pair of neighbouring address bits. The adder and the decoder are merged into one shallow structure.

The array is split into an even-line bank and an odd-line bank. Each bank row accepts two neighbouring index values, so each bank raises the row that holds one of the line index I and the line index I+1. Here I is the sum of the operands' index bits. Later logic uses the carry out of the low, in-line byte bits to choose which of the two fetched words is wanted. The wordline vectors are registered once, so they appear one clock after the operands.

Top module: `sum_wl_decoder`

## Requirements
- R1: While the synchronous active-high reset is sampled high, and on the first clock after it is released, both wordline vectors are all zero.
- R2: The wordline vectors reflect the operands sampled at the previous rising clock edge. Operand changes between edges do not alter them.
- R3: With I = (base[13:3] + offs[13:3]) mod 2048, odd-bank row k (array line 2k+1) is high exactly when I equals 2k or 2k+1.
- R4: Even-bank row k (array line 2k) is high exactly when I equals 2k-1 or 2k, taken modulo 2048.
- R5: Index arithmetic wraps. When I = 2047, even row 0 (line 0) and odd row 1023 (line 2047) are high.
- R6: Outside reset, exactly one bit of the even vector and exactly one bit of the odd vector is high.
- R7: Operand bits 2:0 do not affect either wordline vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_i | input | 14 | Base register value (byte address operand) |
| offs_i | input | 14 | Offset operand |
| even_wl_o | output | 1024 | One-hot wordlines of the even-line bank; bit k selects line 2k |
| odd_wl_o | output | 1024 | One-hot wordlines of the odd-line bank; bit k selects line 2k+1 |

## Verification
The hardest cases to reach are those where the carry-save compare is close to failing. These are the index sums where a carry ripples across the whole index field, including the wrap from 2047 to line 0, and the operand pairs whose index bits differ from the row number in only the lowest compared bit. Random operands rarely land on them. The stimulus therefore drives directed pairs: sums of 0, 1, 1023, 1024 and 2047, built from different splits between base and offset (such as all ones plus zero, or half plus half minus one). It also reuses the same index bits with every low-bit pattern. After that, several thousand random pairs are compared against a plain-adder model on every clock.

// File: rtl/sum_wl_decoder_pkg.sv
package sum_wl_decoder_pkg;
  // Which half of the array a row bank serves; the value is the line parity.
  typedef enum logic {
    BANK_EVEN = 1'b0,
    BANK_ODD  = 1'b1
  } bank_e;
endpackage

// File: rtl/swd_term_gen.sv
// Shared per-bit compare terms. For index bit j (1..IDXW-1) the row's
// carry-save check bit depends only on (L[j], L[j-1]); all four variants
// are produced once here and routed across every row.
module swd_term_gen #(
  parameter int IDXW = 11,
  localparam int NT = IDXW - 1
) (
  input  logic [IDXW-1:0] a_i,
  input  logic [IDXW-1:0] b_i,
  output logic [NT-1:0]   hit11_o,  // row bits L[j]=1, L[j-1]=1
  output logic [NT-1:0]   hit10_o,  // L[j]=1, L[j-1]=0
  output logic [NT-1:0]   hit01_o,  // L[j]=0, L[j-1]=1
  output logic [NT-1:0]   hit00_o   // L[j]=0, L[j-1]=0
);
  for (genvar j = 1; j < IDXW; j++) begin : g_bit
    logic half_sum;
    logic t_and;
    logic t_or;
    assign half_sum = a_i[j] ^ b_i[j];
    assign t_and    = half_sum ^ (a_i[j-1] & b_i[j-1]);
    assign t_or     = half_sum ^ (a_i[j-1] | b_i[j-1]);
    assign hit11_o[j-1] = t_and;
    assign hit10_o[j-1] = t_or;
    assign hit01_o[j-1] = ~t_and;
    assign hit00_o[j-1] = ~t_or;
  end
endmodule

// File: rtl/swd_bank_rows.sv
// One bank of wordline rows. Row k serves array line 2k+PARITY; each row
// picks one shared term per bit by its constant line number and ANDs them.
module swd_bank_rows
  import sum_wl_decoder_pkg::*;
#(
  parameter int    IDXW   = 11,
  parameter bank_e PARITY = BANK_EVEN,
  localparam int   NT     = IDXW - 1,
  localparam int   ROWS   = 1 << (IDXW - 1)
) (
  input  logic [NT-1:0]   hit11_i,
  input  logic [NT-1:0]   hit10_i,
  input  logic [NT-1:0]   hit01_i,
  input  logic [NT-1:0]   hit00_i,
  output logic [ROWS-1:0] wl_o
);
  localparam int PAR = (PARITY == BANK_ODD) ? 1 : 0;

  for (genvar k = 0; k < ROWS; k++) begin : g_row
    localparam int LNUM = 2 * k + PAR;
    localparam logic [IDXW-1:0] LV = LNUM[IDXW-1:0];
    logic [NT-1:0] pick;
    for (genvar j = 1; j < IDXW; j++) begin : g_sel
      if (LV[j] && LV[j-1]) begin : g_11
        assign pick[j-1] = hit11_i[j-1];
      end else if (LV[j]) begin : g_10
        assign pick[j-1] = hit10_i[j-1];
      end else if (LV[j-1]) begin : g_01
        assign pick[j-1] = hit01_i[j-1];
      end else begin : g_00
        assign pick[j-1] = hit00_i[j-1];
      end
    end
    assign wl_o[k] = &pick;
  end
endmodule

// File: rtl/sum_wl_decoder.sv
module sum_wl_decoder
  import sum_wl_decoder_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int LINE_LSB = 3,
  localparam int IDXW    = ADDR_W - LINE_LSB,
  localparam int NT      = IDXW - 1,
  localparam int ROWS    = 1 << (IDXW - 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] offs_i,
  output logic [ROWS-1:0]   even_wl_o,
  output logic [ROWS-1:0]   odd_wl_o
);
  // In-line byte bits only steer data later; they never reach a row.
  logic unused_low;
  assign unused_low = ^{base_i[LINE_LSB-1:0], offs_i[LINE_LSB-1:0]};

  logic [NT-1:0]   h11, h10, h01, h00;
  logic [ROWS-1:0] even_d, odd_d;

  swd_term_gen #(.IDXW(IDXW)) u_terms (
    .a_i     (base_i[ADDR_W-1:LINE_LSB]),
    .b_i     (offs_i[ADDR_W-1:LINE_LSB]),
    .hit11_o (h11),
    .hit10_o (h10),
    .hit01_o (h01),
    .hit00_o (h00)
  );

  swd_bank_rows #(.IDXW(IDXW), .PARITY(BANK_EVEN)) u_even (
    .hit11_i (h11), .hit10_i (h10), .hit01_i (h01), .hit00_i (h00),
    .wl_o    (even_d)
  );

  swd_bank_rows #(.IDXW(IDXW), .PARITY(BANK_ODD)) u_odd (
    .hit11_i (h11), .hit10_i (h10), .hit01_i (h01), .hit00_i (h00),
    .wl_o    (odd_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      even_wl_o <= '0;
      odd_wl_o  <= '0;
    end else begin
      even_wl_o <= even_d;
      odd_wl_o  <= odd_d;
    end
  end
endmodule

// File: rtl/sum_wl_decoder_chk.sv
module sum_wl_decoder_chk #(
  parameter int ADDR_W   = 14,
  parameter int LINE_LSB = 3,
  localparam int IDXW    = ADDR_W - LINE_LSB,
  localparam int ROWS    = 1 << (IDXW - 1)
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] offs_i,
  input logic [ROWS-1:0]   even_wl_o,
  input logic [ROWS-1:0]   odd_wl_o
);
  logic            primed;
  logic [IDXW-1:0] q_idx;
  logic [IDXW-1:0] ev_line, od_line;

  // Plain-adder index of the operands captured at the last edge.
  always_ff @(posedge clk) begin
    primed <= !rst;
    q_idx  <= base_i[ADDR_W-1:LINE_LSB] + offs_i[ADDR_W-1:LINE_LSB];
  end

  assign ev_line = q_idx + {{(IDXW-1){1'b0}}, q_idx[0]};
  assign od_line = q_idx + {{(IDXW-1){1'b0}}, ~q_idx[0]};

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    !primed |-> (even_wl_o == '0 && odd_wl_o == '0));

  p_onehot_r6: assert property (@(posedge clk) disable iff (rst)
    primed |-> ($countones(even_wl_o) == 1 && $countones(odd_wl_o) == 1));

  p_odd_hit_r3: assert property (@(posedge clk) disable iff (rst)
    primed |-> odd_wl_o[od_line[IDXW-1:1]]);

  p_even_hit_r4: assert property (@(posedge clk) disable iff (rst)
    primed |-> even_wl_o[ev_line[IDXW-1:1]]);

  p_wrap_r5: assert property (@(posedge clk) disable iff (rst)
    (primed && q_idx == '1) |-> (even_wl_o[0] && odd_wl_o[ROWS-1]));
endmodule

bind sum_wl_decoder sum_wl_decoder_chk #(.ADDR_W(ADDR_W), .LINE_LSB(LINE_LSB)) u_chk (.*);

// File: tb/test_sum_wl_decoder.sv
`timescale 1ns/1ps
module test_sum_wl_decoder;
  localparam int AW   = 14;
  localparam int ROWS = 1024;
  localparam int NIDX = 2048;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [AW-1:0]   base_i = '0;
  logic [AW-1:0]   offs_i = '0;
  logic [ROWS-1:0] even_wl_o, odd_wl_o;

  int compared   = 0;
  int mismatched = 0;

  always #2 clk = ~clk;  // 250 MHz

  sum_wl_decoder i_sum_wl_decoder (
    .clk(clk), .rst(rst), .base_i(base_i), .offs_i(offs_i),
    .even_wl_o(even_wl_o), .odd_wl_o(odd_wl_o)
  );

  function automatic int first_row(input logic [ROWS-1:0] v);
    for (int k = 0; k < ROWS; k++) if (v[k]) return k;
    return -1;
  endfunction

  function automatic int pop(input logic [ROWS-1:0] v);
    int n = 0;
    for (int k = 0; k < ROWS; k++) if (v[k]) n++;
    return n;
  endfunction

  // Compare both vectors against expectations for operands b, o.
  task automatic check_for(input int b, input int o, input string req);
    int idx, ev, od;
    logic [ROWS-1:0] exp_e, exp_o;
    idx = ((b >> 3) + (o >> 3)) % NIDX;
    ev  = (idx % 2 == 0) ? idx : (idx + 1) % NIDX;
    od  = (idx % 2 == 1) ? idx : (idx + 1) % NIDX;
    exp_e = '0; exp_e[ev / 2] = 1'b1;
    exp_o = '0; exp_o[od / 2] = 1'b1;
    compared++;
    if (even_wl_o !== exp_e) begin
      mismatched++;
      $display("FAIL %s even: actual row %0d (ones %0d) expected row %0d (idx %0d)",
               req, first_row(even_wl_o), pop(even_wl_o), ev / 2, idx);
    end
    compared++;
    if (odd_wl_o !== exp_o) begin
      mismatched++;
      $display("FAIL %s odd: actual row %0d (ones %0d) expected row %0d (idx %0d)",
               req, first_row(odd_wl_o), pop(odd_wl_o), od / 2, idx);
    end
  endtask

  task automatic apply(input int b, input int o, input string req);
    @(negedge clk);
    base_i = AW'(b);
    offs_i = AW'(o);
    @(posedge clk);
    #1;
    check_for(b, o, req);
  endtask

  task automatic check_zero(input string req);
    compared++;
    if (even_wl_o !== '0 || odd_wl_o !== '0) begin
      mismatched++;
      $display("FAIL %s reset: actual ones %0d/%0d expected 0/0",
               req, pop(even_wl_o), pop(odd_wl_o));
    end
  endtask

  initial begin
    #(4.0 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual run still active, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    base_i = 14'h3FF8; offs_i = 14'h0123;
    repeat (3) @(posedge clk);
    #1 check_zero("R1");
    @(negedge clk) rst = 1'b0;
    #1 check_zero("R1");  // before the first edge without reset

    // R3/R4 basic indices
    apply(0, 0, "R4 idx0");
    apply(8, 0, "R3 idx1");
    apply(16, 0, "R4 idx2");
    apply(1023 * 8, 0, "R3 idx1023");
    apply(512 * 8, 512 * 8, "R4 idx1024");
    apply(1023 * 8, 1 * 8, "R4 idx1024 split");
    // R5 wrap cases
    apply(2047 * 8, 0, "R5 idx2047");
    apply(1024 * 8, 1023 * 8, "R5 idx2047 split");
    apply(2047 * 8, 2047 * 8, "R5 idx2046 wrap");
    apply(2047 * 8, 1 * 8, "R5 idx0 wrap");

    // R7: same index bits with every low-bit pattern
    for (int lo = 0; lo < 64; lo++)
      apply(777 * 8 + (lo % 8), 1300 * 8 + (lo / 8), "R7 low bits");

    // R2: operand change between edges leaves outputs unchanged
    apply(100 * 8, 5 * 8, "R2 hold A");
    @(negedge clk);
    base_i = AW'(1500 * 8);
    offs_i = AW'(3 * 8);
    #1 check_for(100 * 8, 5 * 8, "R2 before edge");
    @(posedge clk);
    #1 check_for(1500 * 8, 3 * 8, "R2 after edge");

    // R6 with R3/R4: random operands
    for (int n = 0; n < 3000; n++)
      apply(int'($urandom_range(0, 16383)), int'($urandom_range(0, 16383)), "R6 random");

    // R1: reset reasserted clears outputs
    @(negedge clk) rst = 1'b1;
    @(posedge clk);
    #1 check_zero("R1 reassert");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule